// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM whose shared data bus never needs an idle cycle when traffic switches between reads and writes. The word is 36 bits wide, built from four 9-bit byte lanes. Each lane holds eight data bits and one parity bit. The depth is set by the address-width parameter. Address and control are registered on a rising clock edge. The data transfer that belongs to that command, read or write, is placed in the same slot for both directions: the bus cycle that ends two edges after the command edge. The design drives read data in that slot. The bus master drives write data in that slot, and the model captures it on the closing edge.

A per-cycle two-stage pipeline follows each pending transfer and produces the bus drive enable. A 2-bit burst counter lets one loaded address serve up to four words, in linear or interleaved order. A freeze input stalls every register. Three chip selects gate new commands. An asynchronous output enable can silence the bus at any moment.

Top module: `zbt_sram`

## Requirements
- R1: A read command sampled at edge N with every chip select active makes the design drive the addressed word on `dq` in the slot between edges N+1 and N+2.
- R2: A write command sampled at edge N stores the value present on `dq` at edge N+2.
- R3: Reads and writes may be issued on consecutive edges in any mix with no idle cycle, and each transfer keeps its own slot.
- R4: While `freeze` is 1, every input is ignored and all internal state holds, including queued transfers, so the data slot of a pending command moves back by the frozen cycles.
- R5: A load (`adv` = 0) with any chip select inactive (`sel0_n` = 1, `sel1` = 0 or `sel2_n` = 1) starts no access, and transfers already queued still complete.
- R6: The design leaves `dq` at high impedance in the slot of a write, of a deselected load and of a burst step that follows one.
- R7: `out_en_n` = 1 releases `dq` immediately, without a clock edge. Returning it to 0 restores the pending read data.
- R8: With `seq_linear` = 1, each `adv` = 1 edge increments the burst count k, and the access address is the loaded address with its low two bits replaced by (low bits + k) mod 4.
- R9: With `seq_linear` = 0, the low two address bits of burst step k are the loaded low bits XOR k.
- R10: `lane_wr_n[g]` = 0, sampled with the write command, lets the write update bits [9g+8:9g]. Lanes whose select is 1 keep their old contents.
- R11: A burst step (`adv` = 1) takes its read/write direction and its selected or deselected state from the load that opened the burst. Chip-select and `rd_wr_n` inputs are ignored on that edge.
- R12: A read issued on the edge after a write to the same address returns the freshly written lanes, merged with the stored contents of the lanes that were not written.
- R13: While `rst` is 1, and in the first slot after it is released, `dq` is high impedance, and no command sampled during reset is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | 1 stalls the whole block for that edge |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write (sampled on loads) |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| adv | input | 1 | 0 = load new address, 1 = advance burst |
| seq_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dq | inout | 36 | Shared data bus |

## Verification
The hardest case to reach is the read-after-write forwarding of R12. It needs a partial-lane write that is still in flight while a read of the same word samples storage. The stimulus table issues a two-lane write and then a read of that word on the very next edge. Only lanes 0 and 2 are selected, so the returned word must mix new and old lanes. The same word is read again once the write has committed, to confirm the stored result. Freeze and the asynchronous output enable are checked with directed sequences, because both move or remove a read that is already queued.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0] lane_mask_t;

    // One queued transfer: whether it exists, its direction, its lane enables
    typedef struct packed {
        logic       valid;
        logic       write;
        lane_mask_t lanes;
    } xfer_t;

    typedef enum logic {
        ORDER_XOR = 1'b0,
        ORDER_ADD = 1'b1
    } burst_order_e;

    // Low two address bits for burst step 'step' from loaded bits 'base'
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] step,
                                             input burst_order_e order);
        logic [1:0] sum;
        sum = base + step;
        return (order == ORDER_ADD) ? sum : (base ^ step);
    endfunction

endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              sel_ok,
    input  logic              load,
    input  logic              rd_wr_n,
    input  lane_mask_t        lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              seq_linear,
    output xfer_t             cmd_q,
    output logic [ADDR_W-1:0] cmd_addr_q
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        step_q;
    logic [1:0]        step_nx;
    logic              dir_wr_q;
    logic              live_q;
    burst_order_e      order;

    assign step_nx = step_q + 2'd1;
    assign order   = seq_linear ? ORDER_ADD : ORDER_XOR;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= '0;
            step_q     <= '0;
            dir_wr_q   <= 1'b0;
            live_q     <= 1'b0;
            cmd_q      <= '0;
            cmd_addr_q <= '0;
        end else if (ce) begin
            if (load) begin
                base_q      <= addr;
                step_q      <= 2'd0;
                dir_wr_q    <= ~rd_wr_n;
                live_q      <= sel_ok;
                cmd_q.valid <= sel_ok;
                cmd_q.write <= ~rd_wr_n;
                cmd_q.lanes <= ~lane_wr_n;
                cmd_addr_q  <= addr;
            end else begin
                step_q      <= step_nx;
                cmd_q.valid <= live_q;
                cmd_q.write <= dir_wr_q;
                cmd_q.lanes <= ~lane_wr_n;
                cmd_addr_q  <= {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_nx, order)};
            end
        end
    end

    p_deselect_r5: assert property (@(posedge clk) disable iff (rst)
        (ce && load && !sel_ok) |=> !cmd_q.valid);

    p_inherit_off_r11: assert property (@(posedge clk) disable iff (rst)
        (ce && !load && !live_q) |=> !cmd_q.valid);

    p_inherit_dir_r11: assert property (@(posedge clk) disable iff (rst)
        (ce && !load && live_q) |=> (cmd_q.valid && (cmd_q.write == $past(dir_wr_q))));

    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ce && !rst) |=> ($stable(cmd_q) && $stable(cmd_addr_q) && $stable(step_q)));

endmodule

// File: rtl/zbt_xfer_pipe.sv
module zbt_xfer_pipe
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  xfer_t             cmd,
    input  logic [ADDR_W-1:0] cmd_addr,
    output xfer_t             data_q,
    output logic [ADDR_W-1:0] data_addr_q,
    output logic              drive_q,
    output logic              rd_fire,
    output logic              wr_fire,
    output logic              same_addr
);

    assign rd_fire   = ce && cmd.valid && !cmd.write;
    assign wr_fire   = ce && data_q.valid && data_q.write;
    assign same_addr = (cmd_addr == data_addr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q      <= '0;
            data_addr_q <= '0;
            drive_q     <= 1'b0;
        end else if (ce) begin
            data_q      <= cmd;
            data_addr_q <= cmd_addr;
            drive_q     <= cmd.valid && !cmd.write;
        end
    end

    p_read_slot_r1: assert property (@(posedge clk) disable iff (rst)
        (ce && cmd.valid && !cmd.write) |=> drive_q);

    p_quiet_slot_r6: assert property (@(posedge clk) disable iff (rst)
        drive_q |-> (data_q.valid && !data_q.write));

    p_pipe_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ce && !rst) |=> ($stable(drive_q) && $stable(data_q)));

endmodule

// File: rtl/zbt_lane_mem.sv
module zbt_lane_mem
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  lane_mask_t        wr_lanes,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              bypass,
    output logic [WORD_W-1:0] rd_q
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] lane_q;
        logic [LANE_W-1:0] lane_in;

        assign lane_in = wr_data[g*LANE_W +: LANE_W];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
                cells[wr_addr] <= lane_in;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (rd_en) begin
                lane_q <= (bypass && wr_lanes[g]) ? lane_in : cells[rd_addr];
            end
        end

        assign rd_q[g*LANE_W +: LANE_W] = lane_q;
    end

    p_forward_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bypass && wr_lanes[0]) |=> (rd_q[LANE_W-1:0] == $past(wr_data[LANE_W-1:0])));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              rd_wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              adv,
    input  logic              seq_linear,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [WORD_W-1:0] dq
);

    logic              ce;
    logic              sel_ok;
    xfer_t             cmd;
    logic [ADDR_W-1:0] cmd_addr;
    xfer_t             data_x;
    logic [ADDR_W-1:0] data_addr;
    logic              drive_q;
    logic              rd_fire;
    logic              wr_fire;
    logic              same_addr;
    logic [WORD_W-1:0] rd_q;
    logic [WORD_W-1:0] bus_in;

    assign ce     = ~freeze;
    assign sel_ok = ~sel0_n & sel1 & ~sel2_n;
    assign bus_in = dq;

    zbt_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce),
        .sel_ok     (sel_ok),
        .load       (~adv),
        .rd_wr_n    (rd_wr_n),
        .lane_wr_n  (lane_wr_n),
        .addr       (addr),
        .seq_linear (seq_linear),
        .cmd_q      (cmd),
        .cmd_addr_q (cmd_addr)
    );

    zbt_xfer_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk         (clk),
        .rst         (rst),
        .ce          (ce),
        .cmd         (cmd),
        .cmd_addr    (cmd_addr),
        .data_q      (data_x),
        .data_addr_q (data_addr),
        .drive_q     (drive_q),
        .rd_fire     (rd_fire),
        .wr_fire     (wr_fire),
        .same_addr   (same_addr)
    );

    zbt_lane_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_fire),
        .wr_lanes (data_x.lanes),
        .wr_addr  (data_addr),
        .wr_data  (bus_in),
        .rd_en    (rd_fire),
        .rd_addr  (cmd_addr),
        .bypass   (wr_fire && same_addr),
        .rd_q     (rd_q)
    );

    assign dq = (drive_q && !out_en_n) ? rd_q : {WORD_W{1'bz}};

    p_no_clash_r3: assert property (@(posedge clk) disable iff (rst)
        drive_q |-> !wr_fire);

endmodule

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;

    localparam int PERIOD = 10;
    localparam logic [35:0] ZV = '1;   // pulled-up bus value when nobody drives
    localparam logic [1:0] OP_NOP = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_AD = 2'd3;

    localparam logic [35:0] D0 = 36'h1_2345_6789, D1 = 36'h9_8765_4321, D2 = 36'h0_A5A5_A5A5;
    localparam logic [35:0] E0 = 36'h2_1111_0021, E1 = 36'h2_2222_0022;
    localparam logic [35:0] E2 = 36'h2_3333_0023, E3 = 36'h2_4444_0020;
    localparam logic [35:0] BM = 36'h1_27FD_67FF;   // D0 with lanes 0 and 2 set to ones

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  a;
        logic [3:0]  bwn;
        logic        drv;
        logic [35:0] wd;
        logic        expd;
        logic [35:0] ed;
    } row_t;

    // row k: command for edge k; slot after edge k: bench drive and expected read
    localparam row_t VEC [26] = '{
        '{OP_WR,  8'h10, 4'h0,    1'b0, 36'h0, 1'b0, 36'h0},
        '{OP_WR,  8'h11, 4'h0,    1'b1, D0,    1'b0, 36'h0},
        '{OP_RD,  8'h10, 4'hF,    1'b1, D1,    1'b0, 36'h0},
        '{OP_WR,  8'h12, 4'h0,    1'b0, 36'h0, 1'b1, D0},
        '{OP_RD,  8'h11, 4'hF,    1'b1, D2,    1'b0, 36'h0},
        '{OP_RD,  8'h12, 4'hF,    1'b0, 36'h0, 1'b1, D1},
        '{OP_NOP, 8'h00, 4'hF,    1'b0, 36'h0, 1'b1, D2},
        '{OP_NOP, 8'h00, 4'hF,    1'b0, 36'h0, 1'b0, 36'h0},
        '{OP_WR,  8'h21, 4'h0,    1'b0, 36'h0, 1'b0, 36'h0},
        '{OP_AD,  8'h00, 4'h0,    1'b1, E0,    1'b0, 36'h0},
        '{OP_AD,  8'h00, 4'h0,    1'b1, E1,    1'b0, 36'h0},
        '{OP_AD,  8'h00, 4'h0,    1'b1, E2,    1'b0, 36'h0},
        '{OP_RD,  8'h20, 4'hF,    1'b1, E3,    1'b0, 36'h0},
        '{OP_AD,  8'h00, 4'hF,    1'b0, 36'h0, 1'b1, E3},
        '{OP_AD,  8'h00, 4'hF,    1'b0, 36'h0, 1'b1, E0},
        '{OP_AD,  8'h00, 4'hF,    1'b0, 36'h0, 1'b1, E1},
        '{OP_NOP, 8'h00, 4'hF,    1'b0, 36'h0, 1'b1, E2},
        '{OP_NOP, 8'h00, 4'hF,    1'b0, 36'h0, 1'b0, 36'h0},
        '{OP_AD,  8'h00, 4'h0,    1'b0, 36'h0, 1'b0, 36'h0},
        '{OP_NOP, 8'h00, 4'hF,    1'b0, 36'h0, 1'b0, 36'h0},
        '{OP_WR,  8'h10, 4'b1010, 1'b0, 36'h0, 1'b0, 36'h0},
        '{OP_RD,  8'h10, 4'hF,    1'b1, ZV,    1'b0, 36'h0},
        '{OP_NOP, 8'h00, 4'hF,    1'b0, 36'h0, 1'b1, BM},
        '{OP_RD,  8'h10, 4'hF,    1'b0, 36'h0, 1'b0, 36'h0},
        '{OP_NOP, 8'h00, 4'hF,    1'b0, 36'h0, 1'b1, BM},
        '{OP_NOP, 8'h00, 4'hF,    1'b0, 36'h0, 1'b0, 36'h0}
    };

    logic clk = 1'b0, rst = 1'b1, freeze = 1'b0;
    logic sel0_n = 1'b1, sel1 = 1'b1, sel2_n = 1'b0;
    logic rd_wr_n = 1'b1, adv = 1'b0, seq_linear = 1'b1, out_en_n = 1'b0;
    logic [3:0] lane_wr_n = 4'hF;
    logic [7:0] addr = 8'h00;
    logic tb_drv = 1'b0;
    logic [35:0] tb_data = 36'h0;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    tri1 [35:0] dq;
    assign dq = tb_drv ? tb_data : 36'bz;

    always #(PERIOD/2) clk = ~clk;

    zbt_sram #(.ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .freeze(freeze), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .rd_wr_n(rd_wr_n), .lane_wr_n(lane_wr_n), .adv(adv),
        .seq_linear(seq_linear), .out_en_n(out_en_n), .addr(addr), .dq(dq)
    );

    task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [3:0] bwn);
        addr = a; lane_wr_n = bwn; sel1 = 1'b1; sel2_n = 1'b0;
        case (op)
            OP_NOP:  begin adv = 1'b0; sel0_n = 1'b1; rd_wr_n = 1'b1; end
            OP_RD:   begin adv = 1'b0; sel0_n = 1'b0; rd_wr_n = 1'b1; end
            OP_WR:   begin adv = 1'b0; sel0_n = 1'b0; rd_wr_n = 1'b0; end
            default: begin adv = 1'b1; sel0_n = 1'b1; rd_wr_n = 1'b1; end
        endcase
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        tb_drv = 1'b0;
        #1;
    endtask

    task automatic check(input string req, input logic [35:0] exp);
        n_run++;
        if (dq !== exp) begin
            n_fail++;
            $display("FAIL %s: dq=%h expected %h", req, dq, exp);
        end
    endtask

    function automatic string tag_of(input int k, input logic expd);
        if (!expd)  return "R6 quiet slot";
        if (k <= 7)  return "R1 R2 R3 mixed traffic";
        if (k <= 16) return "R8 R5 linear burst";
        return "R10 R12 lane write forward";
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R13: reset
        rst = 1'b1;
        issue(OP_RD, 8'h10, 4'hF);
        tick(); tick();
        check("R13 during reset", ZV);
        rst = 1'b0;
        issue(OP_NOP, 8'h00, 4'hF);
        tick();
        check("R13 after release", ZV);

        // table: R1 R2 R3 R6 R8 R10 R11 R12
        for (int k = 0; k < 26; k++) begin
            issue(VEC[k].op, VEC[k].a, VEC[k].bwn);
            tick();
            check(tag_of(k, VEC[k].expd), VEC[k].expd ? VEC[k].ed : ZV);
            tb_drv  = VEC[k].drv;
            tb_data = VEC[k].wd;
        end

        // R4: freeze delays a queued read and drops commands
        issue(OP_RD, 8'h22, 4'hF);
        tick();
        check("R6 before freeze", ZV);
        freeze = 1'b1;
        issue(OP_WR, 8'h22, 4'h0);
        tick();
        check("R4 frozen slot 1", ZV);
        tick();
        check("R4 frozen slot 2", ZV);
        freeze = 1'b0;
        issue(OP_NOP, 8'h00, 4'hF);
        tick();
        check("R4 delayed read", E1);
        issue(OP_RD, 8'h22, 4'hF);
        tick();
        check("R6 idle slot", ZV);
        issue(OP_NOP, 8'h00, 4'hF);
        tick();
        check("R4 frozen write ignored", E1);

        // R7: asynchronous output enable
        issue(OP_RD, 8'h21, 4'hF);
        tick();
        check("R6 idle before oe", ZV);
        issue(OP_NOP, 8'h00, 4'hF);
        tick();
        check("R7 read visible", E0);
        out_en_n = 1'b1; #1;
        check("R7 released", ZV);
        out_en_n = 1'b0; #1;
        check("R7 restored", E0);

        // R9: interleaved burst from 0x21
        seq_linear = 1'b0;
        issue(OP_RD, 8'h21, 4'hF);
        tick();
        check("R6 idle before burst", ZV);
        issue(OP_AD, 8'h00, 4'hF);
        tick();
        check("R9 step0", E0);
        issue(OP_AD, 8'h00, 4'hF);
        tick();
        check("R9 step1", E3);
        issue(OP_AD, 8'h00, 4'hF);
        tick();
        check("R9 step2", E2);
        issue(OP_NOP, 8'h00, 4'hF);
        tick();
        check("R9 step3", E1);
        seq_linear = 1'b1;

        // R5 R11: deselect through the third chip select; pending read completes
        issue(OP_RD, 8'h23, 4'hF);
        tick();
        check("R6 idle", ZV);
        issue(OP_NOP, 8'h00, 4'hF);
        sel0_n = 1'b0; sel2_n = 1'b1;
        tick();
        check("R5 pending read completes", E2);
        issue(OP_AD, 8'h00, 4'hF);
        tick();
        check("R5 deselect slot", ZV);
        issue(OP_NOP, 8'h00, 4'hF);
        tick();
        check("R11 step after deselect", ZV);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule